// File: doc/BRIEF.md
# Paced Test Frame Generator

This block supplies a fixed, repeatable byte stimulus to the input of a digital radio datapath. Once its run input is held high, it sends frames of a fixed length over a byte-wide valid/ready stream. Each frame carries a marker on its opening byte and another on its closing byte.

The frames always come in the same order. The first is all zero bytes. The second holds a short ASCII text at its head, and zeros fill the rest of it. Every frame after that is all zeros, for as long as the block runs.

A pacing counter opens one frame per pacing period. The period is a parameter counted in clock cycles, so one second at the real clock rate becomes a short period in simulation. If a pacing tick arrives while a frame is still being transferred, that frame start waits for the transfer to end. Ticks are not queued. A synchronous reset brings the sequence back to the zero frame that comes first.

Top module: `frame_pattern_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid, out_first and out_last are all low.
- R2: Every frame transfers exactly FRAME_LEN bytes. out_first is high only on the byte with index 0, and out_last is high only on the byte with index FRAME_LEN-1.
- R3: The first frame after reset contains only 0x00 bytes.
- R4: In the second frame, bytes 0 to 11 are the ASCII codes 0x54 0x65 0x73 0x74 0x20 0x73 0x74 0x72 0x69 0x6E 0x67 0x2E ("Test string."). Every later byte of that frame is 0x00.
- R5: The third frame and every frame after it contain only 0x00 bytes.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_first and out_last hold their values. Each byte is accepted exactly once, in order.
- R7: Number the clock edges at which run is sampled high, counting from the edge where it first rises, as 0, 1, 2 and so on. A tick falls on every edge whose number is a multiple of TICK_CYCLES. When the generator is idle, a tick starts a frame, and its first byte is valid right after that edge.
- R8: If a tick falls after a frame's start edge and no later than the edge that accepts its last byte, the next frame follows with no gap. Its first byte is valid right after that acceptance edge. Several such ticks still produce only one deferred start.
- R9: While run is low, no new frame starts, but a frame already under way completes. The next rise of run counts as a tick on its first edge.
- R10: A synchronous reset in the middle of any frame abandons that frame, and the sequence restarts from the all-zero first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables pacing and new frame starts |
| out_ready | input | 1 | Downstream accepts a byte |
| out_valid | output | 1 | A byte is offered |
| out_data | output | 8 | Byte value |
| out_first | output | 1 | Marks byte 0 of a frame |
| out_last | output | 1 | Marks the final byte of a frame |

## Verification
The bench predicts the edge at which every frame starts. It does this first with out_ready held high, where every start lands on a tick. It then alternates slow and fast frames, so that some transfers span one tick or several. A design that queued ticks would then send an extra back-to-back frame. A design that dropped a deferred tick would leave a gap of a whole pacing period.

Every accepted byte is compared with the content expected for its frame. A wrong index into the text, or a frame counter that advanced at the wrong time, shows up as byte mismatches. Two further scenarios cover stopping and reset. In the first, run is dropped in the middle of a frame, to show that the frame completes and that nothing starts again until run returns. In the second, reset lands mid-frame, to show that the sequence restarts from the zero frame rather than carrying on.

// File: rtl/frame_pattern_gen.sv
module frame_pattern_gen #(
  parameter int FRAME_LEN   = 256,
  parameter int TICK_CYCLES = 50_000_000,
  parameter int MSG_LEN     = 12,
  parameter logic [8*MSG_LEN-1:0] MSG = "Test string."
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last
);
  localparam int IW = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;

  logic [PW-1:0]        pace;
  logic [IW-1:0]        idx;
  logic [1:0]           fsel;
  logic                 busy, pend;
  logic                 tick, xfer, at_end, done, start;
  logic [8*MSG_LEN-1:0] shifted;

  assign tick   = run && (pace == '0);
  assign xfer   = busy && out_ready;
  assign at_end = (idx == IW'(FRAME_LEN - 1));
  assign done   = xfer && at_end;
  assign start  = run && (tick || pend) && (!busy || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      pace <= '0;
      pend <= 1'b0;
      busy <= 1'b0;
      idx  <= '0;
      fsel <= 2'd0;
    end else begin
      if (!run || pace == PW'(TICK_CYCLES - 1)) pace <= '0;
      else                                      pace <= pace + PW'(1);
      pend <= run && !start && (pend || tick);
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (done) begin
        busy <= 1'b0;
      end else if (xfer) begin
        idx <= idx + IW'(1);
      end
      if (done && fsel != 2'd2) fsel <= fsel + 2'd1;
    end
  end

  assign shifted   = MSG << {idx, 3'b000};
  assign out_valid = busy;
  assign out_first = busy && (idx == '0);
  assign out_last  = busy && at_end;
  assign out_data  = (busy && fsel == 2'd1 && int'(idx) < MSG_LEN) ?
                     shifted[8*MSG_LEN-1 -: 8] : 8'h00;
endmodule

// File: rtl/frame_pattern_gen_chk.sv
module frame_pattern_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic       out_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_first,
  input logic       out_last
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !out_first && !out_last);
  // R6
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_first) && $stable(out_last));
  // R2
  markers_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    out_first |-> !out_last);
  // R2
  frame_continues_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_last |=> out_valid && !out_first);
  // R2
  next_is_new_frame_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid || out_first);
  // R9
  no_start_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run && !out_valid |=> !out_valid);
endmodule

bind frame_pattern_gen frame_pattern_gen_chk chk_i (
  .clk(clk), .rst(rst), .run(run), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data),
  .out_first(out_first), .out_last(out_last)
);

// File: tb/frame_pattern_gen_tb_top.sv
`timescale 1ns/100ps
module frame_pattern_gen_tb_top;
  localparam int FL = 256;
  localparam int T  = 300;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, out_ready = 1'b0;
  logic out_valid, out_first, out_last;
  logic [7:0] out_data;

  frame_pattern_gen #(.FRAME_LEN(FL), .TICK_CYCLES(T)) dut_i (
    .clk(clk), .rst(rst), .run(run), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, ncyc = 0, j = -1;
  bit wd = 0;
  string msg = "Test string.";
  int midx = 0, mframe = 0, frames_done = 0, pred = 0, mode = 0;
  bit started = 0, have_pred = 0, deferred = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_byte(int f, int i);
    if (f == 1 && i < msg.len()) return int'(msg[i]);
    return 0;
  endfunction

  task automatic observe();
    if (out_valid && midx == 0 && !started) begin
      started = 1;
      if (have_pred) chk(j == pred, deferred ? "R8 start edge" : "R7 start edge", j, pred);
    end
    if (out_valid && out_ready) begin
      chk(int'(out_data) == exp_byte(mframe, midx),
          mframe == 0 ? "R3 data" : (mframe == 1 ? "R4 data" : "R5 data"),
          int'(out_data), exp_byte(mframe, midx));
      chk(out_first == (midx == 0), "R2 first", int'(out_first), int'(midx == 0));
      chk(out_last == (midx == FL - 1), "R2 last", int'(out_last), int'(midx == FL - 1));
      midx++;
      if (midx == FL) begin
        int e;
        e = j + 1;
        midx = 0; started = 0; mframe++; frames_done++;
        if (run) begin
          deferred  = (e / T) > (pred / T);
          pred      = deferred ? e : ((e / T) + 1) * T;
          have_pred = 1;
        end else have_pred = 0;
      end
    end else if (!out_valid && started) begin
      chk(0, "R6 valid dropped", 0, 1);
      started = 0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst || !run) j = -1; else j++;
    ncyc++;
    if (ncyc > 150000) wd = 1;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (mode == 0) out_ready = 1'b1;
    else out_ready = (mframe % 2 == 1) ? (lfsr[1:0] == 2'b00) : 1'b1;
    if (rst) chk(!out_valid && !out_first && !out_last, "R1 idle in reset",
                 int'(out_valid), 0);
    else observe();
  endtask

  task automatic model_reset();
    midx = 0; mframe = 0; started = 0; pred = 0; have_pred = 1; deferred = 0;
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    model_reset();
    repeat (20) begin
      step();
      chk(!out_valid, "R9 idle while stopped", int'(out_valid), 0);
    end
    run = 1'b1;
    while (frames_done < 4 && !wd) step();
    mode = 1;
    while (frames_done < 12 && !wd) step();
    mode = 0;
    while (!(out_valid && midx == 100) && !wd) step();
    run = 1'b0; have_pred = 0;
    while (midx != 0 && !wd) step();
    repeat (3 * T) begin
      step();
      chk(!out_valid, "R9 no start while stopped", int'(out_valid), 0);
    end
    run = 1'b1; pred = 0; have_pred = 1; deferred = 0;
    while (frames_done < 15 && !wd) step();
    while (!(out_valid && midx == 50) && !wd) step();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    model_reset();
    begin
      int target;
      target = frames_done + 3;
      while (frames_done < target && !wd) step();
      chk(mframe == 3, "R10 restart sequence", mframe, 3);
    end
    if (wd) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", ncyc, 150000);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule